// File: doc/BRIEF.md
# Parallel Video to Stream Bridge

This block takes pixels from a parallel video bus and hands them to a downstream consumer as a ready/valid AXI4-Stream video master. The video side runs on a pixel clock. It carries a data-enable qualifier, four active-high timing strobes (vertical sync, horizontal sync, vertical blank, horizontal blank) and a pixel word whose width is a parameter. The stream side runs on its own clock. Pixels cross from one clock to the other through a small dual-clock FIFO with Gray-coded pointers.

The bridge writes each pixel into the FIFO one pixel clock late. This lets it know, when data enable drops, which word closed the line, so it tags that word as end of line. The first pixel captured after a rising edge of vertical sync is tagged as start of frame. On the stream side the FIFO is drained to the end of every line. The read that follows the end-of-line word finds the FIFO empty, so the empty-read status pulses once per line during normal operation. A stream enable input holds the stream idle and forces the data lines low. Registered copies of the timing strobes and of an active-video flag are driven out for downstream timing users.

Top module: `vid_stream_bridge`

## Requirements
- R1: Every pixel presented while `pixDe` is high appears exactly once on `mTdata`, in arrival order, and no word is produced for a cycle with `pixDe` low.
- R2: `mTlast` is high on the word carrying the last pixel before `pixDe` falls, and low on every other word.
- R3: `mTuser` is high on the first pixel captured after a rising edge of `pixVsync`, and low on every other word.
- R4: In the stream cycle that follows the transfer of an end-of-line word, if the FIFO is then empty, `emptyRead` is high for exactly one stream clock. When lines are separated by blanking, this gives one pulse per line.
- R5: While `streamEn` is low, `mTdata` is all zeros, `mTvalid` is low, and no word leaves the FIFO. Once `streamEn` is high again, the stored words are delivered.
- R6: While `mTvalid` is high and `mTready` is low, `mTdata`, `mTuser` and `mTlast` keep their values and `mTvalid` stays high.
- R7: The FIFO holds `FIFO_DEPTH` words. A pixel word that arrives while the FIFO is full is dropped, and `overflow` goes high and stays high until pixel reset.
- R8: `tmVsync`, `tmHsync`, `tmVblank` and `tmHblank` equal the matching input one pixel clock earlier. `tmActive` equals `pixDe` one pixel clock earlier (1 = active video, 0 = blanking).
- R9: Under reset, `mTvalid`, `emptyRead`, `overflow` and all `tm*` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pixClk | input | 1 | Pixel clock |
| pixRstN | input | 1 | Pixel-domain reset, active low |
| pixDe | input | 1 | Data enable, high during active video |
| pixVsync | input | 1 | Vertical sync, active high |
| pixHsync | input | 1 | Horizontal sync, active high |
| pixVblank | input | 1 | Vertical blank, active high |
| pixHblank | input | 1 | Horizontal blank, active high |
| pixData | input | DATA_W | Pixel word |
| strmClk | input | 1 | Stream clock |
| strmRstN | input | 1 | Stream-domain reset, active low |
| streamEn | input | 1 | Stream enable; low holds the stream idle with zero data |
| mTdata | output | DATA_W | Stream pixel data |
| mTvalid | output | 1 | Stream valid |
| mTready | input | 1 | Stream ready from the consumer |
| mTuser | output | 1 | Start of frame |
| mTlast | output | 1 | End of line |
| emptyRead | output | 1 | Pulse: a read was attempted on an empty FIFO |
| overflow | output | 1 | Sticky: a pixel was dropped because the FIFO was full |
| tmVsync | output | 1 | Registered vertical sync |
| tmHsync | output | 1 | Registered horizontal sync |
| tmVblank | output | 1 | Registered vertical blank |
| tmHblank | output | 1 | Registered horizontal blank |
| tmActive | output | 1 | Registered active-video flag |

## Verification
The bench builds the bridge with a 12-bit pixel word and an 8-word FIFO. With that depth, a single 12-pixel line sent while the stream is disabled fills the FIFO and then drops words, which exercises the overflow path and a line that loses its end-of-line tag. The pixel clock runs at 20 ns and the stream clock at 14 ns. Because the two clocks are unrelated, the Gray pointers and synchronisers work across changing phase. Ready is run both always-on and pseudo-random, so backpressure holds words on the output for several cycles.

// File: rtl/vsb_pkg.sv
`timescale 1ns/1ps
package vsb_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic holdLoad;   // capture the incoming pixel into the hold stage
    logic sofTag;     // start-of-frame tag for the pixel being captured
    logic fifoWrite;  // push the held pixel into the crossing FIFO
    logic eolTag;     // the pushed word closes the line
    logic outLoad;    // pop the FIFO head into the output stage
    logic outClear;   // output stage emptied with nothing to refill it
  } vsbStrobes_t;

endpackage

// File: rtl/vsb_cdc_fifo.sv
`timescale 1ns/1ps
module vsb_cdc_fifo #(
  parameter int WIDTH = 26,
  parameter int DEPTH = 32   // power of two, at least 4
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             full,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];

  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] rdGraySync1, rdGraySync2;
  logic [PW-1:0] wrGraySync1, wrGraySync2;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Write side
  assign wrBinNext = wrBin + PW'(wrEn && !full);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrEn && !full) mem[wrBin[AW-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
    end else begin
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
    end
  end

  // Full when the write pointer is one lap ahead: top two Gray bits differ
  assign full = (wrGray == {~rdGraySync2[PW-1:PW-2], rdGraySync2[PW-3:0]});

  // Read side
  assign rdBinNext = rdBin + PW'(rdEn && !empty);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
    end else begin
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
    end
  end

  assign empty  = (rdGray == wrGraySync2);
  assign rdData = mem[rdBin[AW-1:0]];

endmodule

// File: rtl/vsb_ctrl.sv
`timescale 1ns/1ps
module vsb_ctrl
  import vsb_pkg::*;
(
  input  logic        pixClk,
  input  logic        pixRstN,
  input  logic        pixDe,
  input  logic        pixVsync,
  input  logic        fifoFull,
  input  logic        strmClk,
  input  logic        strmRstN,
  input  logic        streamEn,
  input  logic        mTready,
  input  logic        fifoEmpty,
  input  logic        headEol,
  input  logic        outValid,
  output vsbStrobes_t strobes,
  output logic        emptyRead,
  output logic        overflow
);
  // Pixel-domain state
  logic vsyncPrev;
  logic holdValid;
  logic sofPending;
  logic vsyncRise;

  // Stream-domain state
  logic flushProbe;
  logic loadReq;

  assign vsyncRise = pixVsync && !vsyncPrev;

  // The output stage may take a new word when enabled and not blocked
  assign loadReq = streamEn && (!outValid || mTready);

  always_comb begin
    strobes.holdLoad  = pixDe;
    strobes.sofTag    = sofPending;
    strobes.fifoWrite = holdValid && !fifoFull;
    strobes.eolTag    = !pixDe;
    strobes.outLoad   = loadReq && !fifoEmpty;
    strobes.outClear  = loadReq && fifoEmpty;
  end

  always_ff @(posedge pixClk or negedge pixRstN) begin
    if (!pixRstN) begin
      vsyncPrev  <= 1'b0;
      holdValid  <= 1'b0;
      sofPending <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      vsyncPrev <= pixVsync;
      holdValid <= pixDe;
      if (vsyncRise)  sofPending <= 1'b1;
      else if (pixDe) sofPending <= 1'b0;
      if (holdValid && fifoFull) overflow <= 1'b1;
    end
  end

  // After an end-of-line word is loaded, the next read attempt probes the
  // FIFO; finding it empty marks the completed flush of that line.
  always_ff @(posedge strmClk or negedge strmRstN) begin
    if (!strmRstN) begin
      flushProbe <= 1'b0;
      emptyRead  <= 1'b0;
    end else begin
      emptyRead <= loadReq && fifoEmpty && flushProbe;
      if (strobes.outLoad && headEol) flushProbe <= 1'b1;
      else if (loadReq)               flushProbe <= 1'b0;
    end
  end

endmodule

// File: rtl/vsb_datapath.sv
`timescale 1ns/1ps
module vsb_datapath
  import vsb_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              pixClk,
  input  logic              pixRstN,
  input  logic              pixDe,
  input  logic              pixVsync,
  input  logic              pixHsync,
  input  logic              pixVblank,
  input  logic              pixHblank,
  input  logic [DATA_W-1:0] pixData,
  input  logic              strmClk,
  input  logic              strmRstN,
  input  logic              streamEn,
  input  vsbStrobes_t       strobes,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              headEol,
  output logic              outValid,
  output logic              mTvalid,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTuser,
  output logic              mTlast,
  output logic              tmVsync,
  output logic              tmHsync,
  output logic              tmVblank,
  output logic              tmHblank,
  output logic              tmActive
);
  // FIFO word: {sof, eol, pixel}
  localparam int WORD_W = DATA_W + 2;

  logic [DATA_W-1:0] holdData;
  logic              holdSof;
  logic [WORD_W-1:0] fifoWrData;
  logic [WORD_W-1:0] fifoRdData;

  logic [DATA_W-1:0] outData;
  logic              outSof;
  logic              outEol;

  // Hold stage: one pixel of delay so the line end is known when writing
  always_ff @(posedge pixClk or negedge pixRstN) begin
    if (!pixRstN) begin
      holdData <= '0;
      holdSof  <= 1'b0;
    end else if (strobes.holdLoad) begin
      holdData <= pixData;
      holdSof  <= strobes.sofTag;
    end
  end

  assign fifoWrData = {holdSof, strobes.eolTag, holdData};

  // Timing pass-through, one pixel clock of latency
  always_ff @(posedge pixClk or negedge pixRstN) begin
    if (!pixRstN) begin
      tmVsync  <= 1'b0;
      tmHsync  <= 1'b0;
      tmVblank <= 1'b0;
      tmHblank <= 1'b0;
      tmActive <= 1'b0;
    end else begin
      tmVsync  <= pixVsync;
      tmHsync  <= pixHsync;
      tmVblank <= pixVblank;
      tmHblank <= pixHblank;
      tmActive <= pixDe;
    end
  end

  vsb_cdc_fifo #(
    .WIDTH (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .wrClk  (pixClk),
    .wrRstN (pixRstN),
    .wrEn   (strobes.fifoWrite),
    .wrData (fifoWrData),
    .full   (fifoFull),
    .rdClk  (strmClk),
    .rdRstN (strmRstN),
    .rdEn   (strobes.outLoad),
    .rdData (fifoRdData),
    .empty  (fifoEmpty)
  );

  assign headEol = fifoRdData[DATA_W];

  // Output register stage
  always_ff @(posedge strmClk or negedge strmRstN) begin
    if (!strmRstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
    end else if (strobes.outLoad) begin
      outValid <= 1'b1;
      outData  <= fifoRdData[DATA_W-1:0];
      outEol   <= fifoRdData[DATA_W];
      outSof   <= fifoRdData[DATA_W+1];
    end else if (strobes.outClear) begin
      outValid <= 1'b0;
    end
  end

  // Enable gate on the stream
  assign mTvalid = outValid && streamEn;
  assign mTdata  = streamEn ? outData : '0;
  assign mTuser  = outSof && streamEn;
  assign mTlast  = outEol && streamEn;

endmodule

// File: rtl/vid_stream_bridge.sv
`timescale 1ns/1ps
module vid_stream_bridge
  import vsb_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              pixClk,
  input  logic              pixRstN,
  input  logic              pixDe,
  input  logic              pixVsync,
  input  logic              pixHsync,
  input  logic              pixVblank,
  input  logic              pixHblank,
  input  logic [DATA_W-1:0] pixData,
  input  logic              strmClk,
  input  logic              strmRstN,
  input  logic              streamEn,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTvalid,
  input  logic              mTready,
  output logic              mTuser,
  output logic              mTlast,
  output logic              emptyRead,
  output logic              overflow,
  output logic              tmVsync,
  output logic              tmHsync,
  output logic              tmVblank,
  output logic              tmHblank,
  output logic              tmActive
);
  vsbStrobes_t strobes;
  logic        fifoFull;
  logic        fifoEmpty;
  logic        headEol;
  logic        outValid;

  vsb_ctrl u_ctrl (
    .pixClk    (pixClk),
    .pixRstN   (pixRstN),
    .pixDe     (pixDe),
    .pixVsync  (pixVsync),
    .fifoFull  (fifoFull),
    .strmClk   (strmClk),
    .strmRstN  (strmRstN),
    .streamEn  (streamEn),
    .mTready   (mTready),
    .fifoEmpty (fifoEmpty),
    .headEol   (headEol),
    .outValid  (outValid),
    .strobes   (strobes),
    .emptyRead (emptyRead),
    .overflow  (overflow)
  );

  vsb_datapath #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dp (
    .pixClk    (pixClk),
    .pixRstN   (pixRstN),
    .pixDe     (pixDe),
    .pixVsync  (pixVsync),
    .pixHsync  (pixHsync),
    .pixVblank (pixVblank),
    .pixHblank (pixHblank),
    .pixData   (pixData),
    .strmClk   (strmClk),
    .strmRstN  (strmRstN),
    .streamEn  (streamEn),
    .strobes   (strobes),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .headEol   (headEol),
    .outValid  (outValid),
    .mTvalid   (mTvalid),
    .mTdata    (mTdata),
    .mTuser    (mTuser),
    .mTlast    (mTlast),
    .tmVsync   (tmVsync),
    .tmHsync   (tmHsync),
    .tmVblank  (tmVblank),
    .tmHblank  (tmHblank),
    .tmActive  (tmActive)
  );

endmodule

// File: rtl/vsb_bridge_chk.sv
`timescale 1ns/1ps
module vsb_bridge_chk #(
  parameter int DATA_W = 24
) (
  input logic              pixClk,
  input logic              pixRstN,
  input logic              pixDe,
  input logic              pixVsync,
  input logic              pixHsync,
  input logic              pixVblank,
  input logic              pixHblank,
  input logic              strmClk,
  input logic              strmRstN,
  input logic              streamEn,
  input logic [DATA_W-1:0] mTdata,
  input logic              mTvalid,
  input logic              mTready,
  input logic              mTuser,
  input logic              mTlast,
  input logic              emptyRead,
  input logic              overflow,
  input logic              tmVsync,
  input logic              tmHsync,
  input logic              tmVblank,
  input logic              tmHblank,
  input logic              tmActive
);
  // Set after the first pixel edge out of reset, so $past is meaningful
  logic pixArmed;
  always_ff @(posedge pixClk or negedge pixRstN) begin
    if (!pixRstN) pixArmed <= 1'b0;
    else          pixArmed <= 1'b1;
  end

  // R5
  stream_gate_chk: assert property (@(posedge strmClk) disable iff (!strmRstN)
    !streamEn |-> (mTdata == '0 && !mTvalid));

  // R6
  hold_stable_chk: assert property (@(posedge strmClk) disable iff (!strmRstN)
    (mTvalid && !mTready) |=>
      (!streamEn || (mTvalid && $stable(mTdata) && $stable(mTuser) && $stable(mTlast))));

  // R4
  empty_pulse_chk: assert property (@(posedge strmClk) disable iff (!strmRstN)
    emptyRead |=> !emptyRead);

  // R7
  overflow_sticky_chk: assert property (@(posedge pixClk) disable iff (!pixRstN)
    overflow |=> overflow);

  // R8
  passthru_chk: assert property (@(posedge pixClk) disable iff (!pixRstN)
    pixArmed |-> (tmVsync == $past(pixVsync) && tmHsync == $past(pixHsync) &&
                  tmVblank == $past(pixVblank) && tmHblank == $past(pixHblank) &&
                  tmActive == $past(pixDe)));

endmodule

bind vid_stream_bridge vsb_bridge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/vid_stream_bridge_tb.sv
`timescale 1ns/1ps
module vid_stream_bridge_tb;
  localparam int DW    = 12;
  localparam int DEPTH = 8;

  logic          pixClk = 1'b0;
  logic          strmClk = 1'b0;
  logic          pixRstN, strmRstN;
  logic          pixDe, pixVsync, pixHsync, pixVblank, pixHblank;
  logic [DW-1:0] pixData;
  logic          streamEn;
  logic          mTready;
  logic [DW-1:0] mTdata;
  logic          mTvalid, mTuser, mTlast;
  logic          emptyRead, overflow;
  logic          tmVsync, tmHsync, tmVblank, tmHblank, tmActive;

  always #10 pixClk  = ~pixClk;   // 50 MHz
  always #7  strmClk = ~strmClk;

  vid_stream_bridge #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) u_dut (
    .pixClk(pixClk), .pixRstN(pixRstN), .pixDe(pixDe), .pixVsync(pixVsync),
    .pixHsync(pixHsync), .pixVblank(pixVblank), .pixHblank(pixHblank),
    .pixData(pixData), .strmClk(strmClk), .strmRstN(strmRstN),
    .streamEn(streamEn), .mTdata(mTdata), .mTvalid(mTvalid), .mTready(mTready),
    .mTuser(mTuser), .mTlast(mTlast), .emptyRead(emptyRead), .overflow(overflow),
    .tmVsync(tmVsync), .tmHsync(tmHsync), .tmVblank(tmVblank),
    .tmHblank(tmHblank), .tmActive(tmActive)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Reference model: expected words {sof, eol, data}
  logic [DW+1:0] expQ[$];
  bit            mHoldValid = 0;
  logic [DW:0]   mHold = '0;
  bit            mSofPend = 0;
  bit            mPrevVs = 0;
  bit            stallMode = 0;
  int            stallWrites = 0;
  bit            ptArmed = 0;
  int            pulseCount = 0;
  int            expPulses = 0;
  bit            readyRandom = 0;

  task automatic emitWord(input logic [DW+1:0] w);
    if (!(stallMode && stallWrites >= DEPTH)) expQ.push_back(w);
    if (stallMode) stallWrites++;
  endtask

  task automatic pixCycle(input bit de, input bit vs, input bit hs, input bit vb,
                          input bit hb, input logic [DW-1:0] d);
    @(negedge pixClk);
    if (ptArmed)
      check(tmVsync === pixVsync && tmHsync === pixHsync && tmVblank === pixVblank &&
            tmHblank === pixHblank && tmActive === pixDe, "R8", "timing pass-through",
            {tmVsync, tmHsync, tmVblank, tmHblank, tmActive},
            {pixVsync, pixHsync, pixVblank, pixHblank, pixDe});
    if (mHoldValid) emitWord({mHold[DW], !de, mHold[DW-1:0]});
    mHoldValid = de;
    if (de) mHold = {mSofPend, d};
    if (vs && !mPrevVs) mSofPend = 1;
    else if (de)        mSofPend = 0;
    mPrevVs = vs;
    pixDe = de; pixVsync = vs; pixHsync = hs; pixVblank = vb; pixHblank = hb;
    pixData = d;
    ptArmed = 1;
  endtask

  task automatic frameStart();
    repeat (2) pixCycle(0, 1, 0, 1, 1, '0);
    repeat (3) pixCycle(0, 0, 0, 1, 1, '0);
  endtask

  task automatic sendLine(input int n, input int base, input int gap, input bit pulses);
    for (int i = 0; i < n; i++) pixCycle(1, 0, 0, 0, 0, DW'(base + i));
    repeat (2) pixCycle(0, 0, 1, 0, 1, '0);
    repeat (gap) pixCycle(0, 0, 0, 0, 1, '0);
    if (pulses) expPulses++;
  endtask

  task automatic setEnable(input bit en);
    @(posedge strmClk);
    #1 streamEn = en;
  endtask

  // Stream-side monitor, compared on every stream clock
  logic [7:0]    lfsr = 8'hA5;
  bit            heldFlag = 0;
  logic [DW-1:0] heldData;
  logic          heldUser, heldLast;

  always @(negedge strmClk) begin
    if (!strmRstN) begin
      mTready = 1'b0;
      heldFlag = 0;
    end else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mTready = readyRandom ? (lfsr[2:0] != 3'b000) : 1'b1;
      if (emptyRead) pulseCount++;
      if (!streamEn)
        check(mTdata == '0 && !mTvalid, "R5", "disabled stream output",
              {mTvalid, mTdata}, 0);
      if (heldFlag && streamEn)
        check(mTvalid && mTdata == heldData && mTuser == heldUser && mTlast == heldLast,
              "R6", "held word under backpressure", {mTvalid, mTuser, mTlast, mTdata},
              {1'b1, heldUser, heldLast, heldData});
      heldFlag = mTvalid && !mTready && streamEn;
      heldData = mTdata; heldUser = mTuser; heldLast = mTlast;
      if (mTvalid && mTready) begin
        if (expQ.size() == 0) check(0, "R1", "unexpected word", mTdata, 0);
        else begin
          logic [DW+1:0] w;
          w = expQ.pop_front();
          check(mTdata == w[DW-1:0], "R1", "pixel data", mTdata, w[DW-1:0]);
          check(mTuser == w[DW+1], "R3", "start of frame", mTuser, w[DW+1]);
          check(mTlast == w[DW], "R2", "end of line", mTlast, w[DW]);
        end
      end
    end
  end

  initial begin
    #2000000;
    check(0, "watchdog", "run timed out", 0, 1);
    finishRun();
  end

  initial begin
    pixRstN = 0; strmRstN = 0; streamEn = 1;
    pixDe = 0; pixVsync = 0; pixHsync = 0; pixVblank = 0; pixHblank = 0;
    pixData = '0;
    repeat (5) @(negedge pixClk);
    // R9 reset state
    check(!mTvalid && !emptyRead && !overflow, "R9", "reset outputs",
          {mTvalid, emptyRead, overflow}, 0);
    check({tmVsync, tmHsync, tmVblank, tmHblank, tmActive} == 5'b0, "R9",
          "reset pass-through", {tmVsync, tmHsync, tmVblank, tmHblank, tmActive}, 0);
    pixRstN = 1; strmRstN = 1;
    repeat (4) pixCycle(0, 0, 0, 0, 1, '0);

    // Frame with ready held high, lines of varied length
    frameStart();
    sendLine(8, 'h100, 40, 1);
    sendLine(5, 'h200, 40, 1);
    sendLine(10, 'h300, 40, 1);
    check(expQ.size() == 0, "R1", "queue drained, always ready", expQ.size(), 0);
    check(pulseCount == expPulses, "R4", "one empty pulse per line", pulseCount, expPulses);

    // Frame with pseudo-random backpressure
    readyRandom = 1;
    frameStart();
    sendLine(6, 'h410, 40, 1);
    sendLine(6, 'h420, 40, 1);
    sendLine(1, 'h430, 40, 1);
    readyRandom = 0;
    repeat (10) pixCycle(0, 0, 0, 0, 1, '0);
    check(expQ.size() == 0, "R1", "queue drained, backpressure", expQ.size(), 0);
    check(pulseCount == expPulses, "R4", "pulses under backpressure", pulseCount, expPulses);

    // Stream disabled: words wait in the FIFO
    setEnable(0);
    sendLine(6, 'h500, 30, 1);
    check(expQ.size() == 6, "R5", "no word consumed while disabled", expQ.size(), 6);
    check(pulseCount == expPulses - 1, "R4", "no pulse while disabled",
          pulseCount, expPulses - 1);
    setEnable(1);
    repeat (30) pixCycle(0, 0, 0, 0, 1, '0);
    check(expQ.size() == 0, "R5", "held words delivered after enable", expQ.size(), 0);
    check(pulseCount == expPulses, "R4", "pulse after enabled drain", pulseCount, expPulses);

    // Overflow: 12 pixels into an 8-word FIFO with the stream stopped
    check(!overflow, "R7", "no overflow yet", overflow, 0);
    setEnable(0);
    stallMode = 1; stallWrites = 0;
    sendLine(12, 'h600, 20, 0);
    @(negedge pixClk);
    check(overflow, "R7", "overflow after dropped words", overflow, 1);
    check(expQ.size() == DEPTH, "R7", "FIFO holds depth words", expQ.size(), DEPTH);
    stallMode = 0;
    setEnable(1);
    repeat (30) pixCycle(0, 0, 0, 0, 1, '0);
    check(expQ.size() == 0, "R7", "stored words delivered", expQ.size(), 0);
    check(pulseCount == expPulses, "R4", "no pulse for line without end tag",
          pulseCount, expPulses);
    check(overflow, "R7", "overflow stays set", overflow, 1);

    finishRun();
  end

endmodule